// File: doc/BRIEF.md
# Eight-Bit Shifting ALU with Zero and Sign Flags

This block is the arithmetic and logic stage of a small accumulator datapath. Each cycle it takes two operands, `a_i` and `b_i`, and a four-bit operation select. It returns one result byte and two status flags: zero and negative. The block supports:

- two pass-through selections;
- wrap-around add and subtract;
- three bitwise operations;
- six shift and rotate operations, each moving `a_i` by the count held in `b_i`.

The operation logic is purely combinational. The result and flags are registered, so a value applied at one rising edge appears on the outputs from that edge until the next one. The shift counts are variable. Logical and arithmetic shifts treat any count of the data width or more as a full shift. Rotates use the count modulo the data width. There is no carry, overflow, multiply or divide.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `res_o` = 0x00, `zero_o` = 1 and `neg_o` = 0.
- R2: Operands and the operation code present at a rising edge with `rst` low decide the outputs from that edge until the next one. Changing the inputs between edges leaves the outputs unchanged.
- R3: The pass-through codes are 0 (result = A) and 1 (result = B). The unassigned codes 13, 14 and 15 also give result = A.
- R4: Code 2 gives (A + B) mod 256. Code 3 gives (A − B) mod 256. No carry or borrow leaves the block.
- R5: Code 4 gives A AND B, code 5 gives A OR B, and code 6 gives A XOR B.
- R6: Code 7 (logical left) and code 9 (arithmetic left) both shift A left by B places and fill with zeros. Any B of 8 or more gives 0x00.
- R7: Code 8 (logical right) shifts A right by B places and fills with zeros. Any B of 8 or more gives 0x00.
- R8: Code 10 (arithmetic right) shifts A right by B places and copies bit 7 of A into every vacated position. Any B of 8 or more gives 0xFF when bit 7 of A is 1 and 0x00 otherwise.
- R9: Code 11 rotates A left and code 12 rotates A right, each by B mod 8 places. Bits that leave one end re-enter at the other.
- R10: `zero_o` is 1 exactly when `res_o` is 0x00.
- R11: `neg_o` equals bit 7 of `res_o`, which is the sign of the result read as a signed byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation select code |
| a_i | input | 8 | First operand; the value that is shifted or rotated |
| b_i | input | 8 | Second operand; the shift or rotate count for shift codes |
| res_o | output | 8 | Registered result |
| zero_o | output | 1 | Registered flag: result is zero |
| neg_o | output | 1 | Registered flag: result bit 7 is set |

## Verification
The assertions check several properties on every cycle:

- the relation between each flag and the registered result;
- the reset values;
- the one-cycle relation between sampled operands and the result for the pass-through, unassigned and add codes;
- the rule that a rotate by a multiple of eight returns A unchanged.

Some behaviour only the bench's sweep can show. This covers the fill values of every shift, the saturation of shift counts at eight and above, sign replication in the arithmetic right shift, and the outputs holding steady while the inputs change between edges. The sweep covers every code and every A value against a spread of counts, and compares each result with a bit-by-bit reference.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PASSA = 4'd0,
    OP_PASSB = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_LSL   = 4'd7,
    OP_LSR   = 4'd8,
    OP_ASL   = 4'd9,
    OP_ASR   = 4'd10,
    OP_RSL   = 4'd11,
    OP_RSR   = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;
endpackage

// File: rtl/alu8_barrel.sv
module alu8_barrel #(
  parameter int W = 8
) (
  input  logic            [W-1:0] data_i,
  input  logic            [W-1:0] amt_i,
  input  logic                    left_i,
  input  alu8_pkg::fill_e         fill_i,
  output logic            [W-1:0] data_o
);
  localparam int SH_W = $clog2(W);

  logic [W-1:0]            src;
  logic [W-1:0]            sat;
  logic [W-1:0]            fin;
  logic [SH_W:0][W-1:0]    stage;
  logic                    fill_bit;
  logic                    wrap;
  logic                    oversize;

  assign wrap     = (fill_i == alu8_pkg::FILL_WRAP);
  assign fill_bit = (fill_i == alu8_pkg::FILL_SIGN) ? data_i[W-1] : 1'b0;
  assign oversize = |amt_i[W-1:SH_W];

  // Left moves are performed as right moves on the bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign src[i] = left_i ? data_i[W-1-i] : data_i[i];
  end

  assign stage[0] = src;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = !amt_i[s] ? stage[s] :
                        wrap      ? {stage[s][D-1:0], stage[s][W-1:D]} :
                                    {{D{fill_bit}}, stage[s][W-1:D]};
  end

  assign sat = {W{fill_bit}};
  assign fin = (oversize && !wrap) ? sat : stage[SH_W];

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign data_o[i] = left_i ? fin[W-1-i] : fin[i];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  alu8_pkg::alu_op_e         op_i,
  input  logic              [W-1:0] a_i,
  input  logic              [W-1:0] b_i,
  output logic              [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      alu8_pkg::OP_PASSB: res_o = b_i;
      alu8_pkg::OP_ADD:   res_o = a_i + b_i;
      alu8_pkg::OP_SUB:   res_o = a_i - b_i;
      alu8_pkg::OP_AND:   res_o = a_i & b_i;
      alu8_pkg::OP_OR:    res_o = a_i | b_i;
      alu8_pkg::OP_XOR:   res_o = a_i ^ b_i;
      default:            res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         zero_o,
  output logic         neg_o
);
  assign zero_o = (res_i == '0);
  assign neg_o  = res_i[W-1];
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [alu8_pkg::OP_W-1:0]  op_i,
  input  logic [DATA_W-1:0]          a_i,
  input  logic [DATA_W-1:0]          b_i,
  output logic [DATA_W-1:0]          res_o,
  output logic                       zero_o,
  output logic                       neg_o
);
  import alu8_pkg::*;

  alu_op_e           op;
  fill_e             fill;
  logic              is_shift;
  logic              go_left;
  logic [DATA_W-1:0] lu_res;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_zero;
  logic              nxt_neg;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_shift = 1'b0;
    go_left  = 1'b0;
    fill     = FILL_ZERO;
    case (op)
      OP_LSL, OP_ASL: begin is_shift = 1'b1; go_left = 1'b1; end
      OP_LSR:         begin is_shift = 1'b1; end
      OP_ASR:         begin is_shift = 1'b1; fill = FILL_SIGN; end
      OP_RSL:         begin is_shift = 1'b1; go_left = 1'b1; fill = FILL_WRAP; end
      OP_RSR:         begin is_shift = 1'b1; fill = FILL_WRAP; end
      default:        ;
    endcase
  end

  alu8_logic #(.W(DATA_W)) logic_i (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lu_res)
  );

  alu8_barrel #(.W(DATA_W)) barrel_i (
    .data_i (a_i),
    .amt_i  (b_i),
    .left_i (go_left),
    .fill_i (fill),
    .data_o (sh_res)
  );

  assign nxt_res = is_shift ? sh_res : lu_res;

  alu8_flags #(.W(DATA_W)) flags_i (
    .res_i  (nxt_res),
    .zero_o (nxt_zero),
    .neg_o  (nxt_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b1;
      neg_o  <= 1'b0;
    end else begin
      res_o  <= nxt_res;
      zero_o <= nxt_zero;
      neg_o  <= nxt_neg;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [alu8_pkg::OP_W-1:0] op_i,
  input logic [DATA_W-1:0]         a_i,
  input logic [DATA_W-1:0]         b_i,
  input logic [DATA_W-1:0]         res_o,
  input logic                      zero_o,
  input logic                      neg_o
);
  localparam int SH_W = $clog2(DATA_W);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && zero_o && !neg_o));

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  assert_neg_flag_R11: assert property (@(posedge clk) disable iff (rst)
    neg_o == res_o[DATA_W-1]);

  assert_pass_a_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd0 || op_i >= 4'd13) |=> res_o == $past(a_i));

  assert_pass_b_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd1) |=> res_o == $past(b_i));

  assert_add_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2) |=> res_o == DATA_W'($past(a_i) + $past(b_i)));

  assert_rotate_full_turn_R9: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 4'd11 || op_i == 4'd12) && b_i[SH_W-1:0] == '0) |=> res_o == $past(a_i));
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .res_o  (res_o),
  .zero_o (zero_o),
  .neg_o  (neg_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op  = '0;
  logic [7:0] a   = '0;
  logic [7:0] b   = '0;
  logic [7:0] res;
  logic       zf;
  logic       nf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu8_core #(.DATA_W(8)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .res_o  (res),
    .zero_o (zf),
    .neg_o  (nf)
  );

  localparam logic [7:0] B_SET [16] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7,
                                        8'd8, 8'd9, 8'd15, 8'd16, 8'd127, 8'd128,
                                        8'd200, 8'd255};

  function automatic logic [7:0] model(input logic [3:0] o, input logic [7:0] x,
                                       input logic [7:0] y);
    logic [7:0] r;
    r = x;
    case (o)
      4'd1:  r = y;
      4'd2:  r = x + y;
      4'd3:  r = x - y;
      4'd4:  r = x & y;
      4'd5:  r = x | y;
      4'd6:  r = x ^ y;
      4'd7, 4'd9: for (int i = 0; i < 8; i++) if (i < y) r = {r[6:0], 1'b0};
      4'd8:  for (int i = 0; i < 8; i++) if (i < y) r = {1'b0, r[7:1]};
      4'd10: for (int i = 0; i < 8; i++) if (i < y) r = {r[7], r[7:1]};
      4'd11: for (int i = 0; i < 8; i++) if (i < (y % 8)) r = {r[6:0], r[7]};
      4'd12: for (int i = 0; i < 8; i++) if (i < (y % 8)) r = {r[0], r[7:1]};
      default: r = x;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd2, 4'd3:       return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7, 4'd9:       return "R6";
      4'd8:             return "R7";
      4'd10:            return "R8";
      4'd11, 4'd12:     return "R9";
      default:          return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               req, op, a, b, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", res, 8'h00);
    check("R1", {7'd0, zf}, 8'h01);
    check("R1", {7'd0, nf}, 8'h00);
    rst = 1'b0;

    // R2: registered, holds between edges
    op = 4'd2; a = 8'd3; b = 8'd4;
    @(negedge clk);
    check("R2", res, 8'd7);
    op = 4'd0; a = 8'd10;
    #1;
    check("R2", res, 8'd7);
    @(negedge clk);
    check("R2", res, 8'd10);

    // Sweep every code, every A, a spread of B values
    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int k = 0; k < 16; k++) begin
          op = 4'(o); a = 8'(x); b = B_SET[k];
          exp = model(op, a, b);
          @(negedge clk);
          check(tag(op), res, exp);
          check("R10", {7'd0, zf}, {7'd0, exp == 8'h00});
          check("R11", {7'd0, nf}, {7'd0, exp[7]});
        end
      end
    end

    // R8: explicit sign saturation corner
    op = 4'd10; a = 8'h80; b = 8'd200;
    @(negedge clk);
    check("R8", res, 8'hFF);
    // R6: oversized left shift clears
    op = 4'd9; a = 8'hFF; b = 8'd8;
    @(negedge clk);
    check("R6", res, 8'h00);

    finish_run();
  end
endmodule